// File: doc/BRIEF.md
# Direct-Mapped Instruction Cache Controller

This block is a read-only, direct-mapped instruction cache. It sits between a processor fetch port and a memory read master. Each line holds eight 32-bit words, which is 32 bytes. The line is picked by an index field taken from the byte address. The low five address bits select a byte within the line, and the bits above the index form the tag. A hit returns the instruction word from on-chip tag and data storage in the cycle after the request is accepted.

On a miss, the controller refills the whole line through the memory master. It issues one word read per cycle. The first read is for the missed word itself, and the following reads wrap around inside the line. The requested word goes back to the fetch port in the same cycle that its beat arrives from memory. The fetch port then stays blocked until all eight beats have been written. Only then does the line become valid.

Fetch back-pressure: a request moves when `fetch_valid` and `fetch_ready` are both high. `fetch_ready` is low while a lookup misses and for the whole refill. The response channel has no ready signal, so the consumer must take `rsp_valid` in the cycle it appears. On the memory side, `mem_waitreq` holds the current read. While it is high, the address and strobe stay unchanged, and the issue position does not advance. Memory returns beats in issue order on `mem_rvalid`. A single-cycle `inv_all` pulse clears every valid bit.

Top module: `icache_ctrl`

## Requirements
- R1: After reset every line is invalid, `fetch_ready` is 1, and `rsp_valid` and `mem_req` are 0. The first fetch of any address after reset misses.
- R2: A fetch accepted on a clock edge that hits produces `rsp_valid`=1 in the following cycle. `rsp_data` then holds the word at byte address bits [ADDR_W-1:2], and `fetch_ready` stays 1, so hits can be streamed back to back.
- R3: A miss on word w (address bits [4:2]) issues word reads whose word addresses (`mem_addr` = byte address >> 2) carry the line's upper bits unchanged. Their low three bits run w, w+1, ... modulo 8.
- R4: On a miss, the requested word is returned with `rsp_valid`=1 in the cycle the first memory beat arrives, and `rsp_data` equals `mem_rdata` in that cycle.
- R5: From the lookup cycle of a miss until the edge that writes the eighth beat, `fetch_ready` is 0. It is 1 in the cycle after that edge.
- R6: While `mem_req` and `mem_waitreq` are both 1, the next cycle still has `mem_req`=1 and the same `mem_addr`.
- R7: Every refill issues exactly eight accepted reads, and `mem_req` is never 1 while `fetch_ready` is 1.
- R8: After a refill completes, fetches to any of the eight words of that line hit with no memory read.
- R9: Two addresses with the same index bits and different tags share one line, so fetching one evicts the other.
- R10: An `inv_all` pulse makes every line miss afterwards. A pulse during a refill leaves the refilled line invalid.
- R11: Each accepted fetch gets exactly one response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inv_all | input | 1 | Pulse: invalidate every line |
| fetch_valid | input | 1 | Fetch request present |
| fetch_ready | output | 1 | Controller can accept a fetch |
| fetch_addr | input | ADDR_W | Fetch byte address (bits [1:0] ignored) |
| rsp_valid | output | 1 | Instruction word valid this cycle |
| rsp_data | output | 32 | Instruction word |
| mem_req | output | 1 | Memory read strobe |
| mem_addr | output | ADDR_W-2 | Memory word address |
| mem_waitreq | input | 1 | Memory stalls the current read |
| mem_rvalid | input | 1 | Read beat valid |
| mem_rdata | input | 32 | Read beat data |

## Verification
The bench builds the controller with INDEX_W=2, so the cache has four lines, and keeps the full 31-bit address. With only 32 line-and-start-word pairs, it can refill every line from every starting word and then read back all eight words as hits. It repeats this sweep under three stall patterns on `mem_waitreq`: none, periodic and pseudo-random. The tiny index space also makes tag conflicts and evictions occur on every sweep step. Invalidation is tested both while the controller is idle and in the middle of a refill.

// File: rtl/icache_pkg.sv
package icache_pkg;
  localparam int OFFSET_W   = 5;
  localparam int WSEL_W     = 3;
  localparam int LINE_WORDS = 1 << WSEL_W;
  localparam int WORD_W     = 32;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_FILL = 1'b1
  } fill_state_e;
endpackage

// File: rtl/icache_tag_store.sv
module icache_tag_store
  import icache_pkg::*;
#(
  parameter int INDEX_W = 7,
  parameter int TAG_W   = 19
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               inv_all,
  input  logic [INDEX_W-1:0] rd_idx,
  output logic               rd_valid,
  output logic [TAG_W-1:0]   rd_tag,
  input  logic               alloc_en,
  input  logic [INDEX_W-1:0] alloc_idx,
  input  logic [TAG_W-1:0]   alloc_tag,
  input  logic               commit_en,
  input  logic [INDEX_W-1:0] commit_idx
);
  localparam int LINES = 1 << INDEX_W;

  logic [LINES-1:0] vld_q;
  logic [TAG_W-1:0] tag_q [LINES];

  for (genvar l = 0; l < LINES; l++) begin : g_line
    always_ff @(posedge clk) begin
      if (!rst_n || inv_all) begin
        vld_q[l] <= 1'b0;
      end else if (alloc_en && alloc_idx == INDEX_W'(l)) begin
        vld_q[l] <= 1'b0;
      end else if (commit_en && commit_idx == INDEX_W'(l)) begin
        vld_q[l] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (alloc_en && alloc_idx == INDEX_W'(l)) begin
        tag_q[l] <= alloc_tag;
      end
    end
  end

  assign rd_valid = vld_q[rd_idx];
  assign rd_tag   = tag_q[rd_idx];
endmodule

// File: rtl/icache_data_store.sv
module icache_data_store
  import icache_pkg::*;
#(
  parameter int INDEX_W = 7
) (
  input  logic               clk,
  input  logic               wr_en,
  input  logic [INDEX_W-1:0] wr_idx,
  input  logic [WSEL_W-1:0]  wr_word,
  input  logic [WORD_W-1:0]  wr_data,
  input  logic [INDEX_W-1:0] rd_idx,
  input  logic [WSEL_W-1:0]  rd_word,
  output logic [WORD_W-1:0]  rd_data
);
  localparam int DEPTH = (1 << INDEX_W) * LINE_WORDS;
  localparam int AW    = INDEX_W + WSEL_W;

  logic [WORD_W-1:0] words_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      words_q[{wr_idx, wr_word}] <= wr_data;
    end
  end

  logic [AW-1:0] rd_ptr;
  assign rd_ptr  = {rd_idx, rd_word};
  assign rd_data = words_q[rd_ptr];
endmodule

// File: rtl/icache_fill_seq.sv
module icache_fill_seq
  import icache_pkg::*;
#(
  parameter int LINE_W = 26
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [LINE_W-1:0]        start_line,
  input  logic [WSEL_W-1:0]        start_word,
  input  logic                     inv_all,
  output logic                     mem_req,
  output logic [LINE_W+WSEL_W-1:0] mem_addr,
  input  logic                     mem_waitreq,
  input  logic                     mem_rvalid,
  output logic                     busy,
  output logic                     beat_we,
  output logic [WSEL_W-1:0]        beat_word,
  output logic                     first_beat,
  output logic                     fill_keep
);
  localparam int CNT_W = WSEL_W + 1;

  fill_state_e       state_q;
  logic [LINE_W-1:0] line_q;
  logic [WSEL_W-1:0] iss_word_q, rcv_word_q;
  logic [CNT_W-1:0]  iss_cnt_q, rcv_cnt_q;
  logic              inv_seen_q;
  logic              last_beat;

  assign busy       = (state_q == ST_FILL);
  assign mem_req    = busy && (iss_cnt_q < CNT_W'(LINE_WORDS));
  assign mem_addr   = {line_q, iss_word_q};
  assign beat_we    = busy && mem_rvalid;
  assign beat_word  = rcv_word_q;
  assign first_beat = beat_we && (rcv_cnt_q == '0);
  assign last_beat  = beat_we && (rcv_cnt_q == CNT_W'(LINE_WORDS - 1));
  assign fill_keep  = last_beat && !inv_seen_q && !inv_all;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      line_q     <= '0;
      iss_word_q <= '0;
      rcv_word_q <= '0;
      iss_cnt_q  <= '0;
      rcv_cnt_q  <= '0;
      inv_seen_q <= 1'b0;
    end else if (state_q == ST_IDLE) begin
      if (start) begin
        state_q    <= ST_FILL;
        line_q     <= start_line;
        iss_word_q <= start_word;
        rcv_word_q <= start_word;
        iss_cnt_q  <= '0;
        rcv_cnt_q  <= '0;
        inv_seen_q <= 1'b0;
      end
    end else begin
      if (mem_req && !mem_waitreq) begin
        iss_word_q <= iss_word_q + 1'b1;
        iss_cnt_q  <= iss_cnt_q + 1'b1;
      end
      if (beat_we) begin
        rcv_word_q <= rcv_word_q + 1'b1;
        rcv_cnt_q  <= rcv_cnt_q + 1'b1;
      end
      if (inv_all) begin
        inv_seen_q <= 1'b1;
      end
      if (last_beat) begin
        state_q <= ST_IDLE;
      end
    end
  end
endmodule

// File: rtl/icache_ctrl.sv
module icache_ctrl
  import icache_pkg::*;
#(
  parameter int ADDR_W  = 31,
  parameter int INDEX_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inv_all,
  input  logic              fetch_valid,
  output logic              fetch_ready,
  input  logic [ADDR_W-1:0] fetch_addr,
  output logic              rsp_valid,
  output logic [31:0]       rsp_data,
  output logic              mem_req,
  output logic [ADDR_W-3:0] mem_addr,
  input  logic              mem_waitreq,
  input  logic              mem_rvalid,
  input  logic [31:0]       mem_rdata
);
  localparam int WADDR_W = ADDR_W - 2;
  localparam int LINE_W  = ADDR_W - OFFSET_W;
  localparam int TAG_W   = LINE_W - INDEX_W;

  logic               accept, pend_q, hit, miss;
  logic [WADDR_W-1:0] addr_q;
  logic [WSEL_W-1:0]  req_word;
  logic [INDEX_W-1:0] req_idx;
  logic [TAG_W-1:0]   req_tag;
  logic               rd_valid;
  logic [TAG_W-1:0]   rd_tag;
  logic [WORD_W-1:0]  rd_data;
  logic               busy, beat_we, first_beat, fill_keep;
  logic [WSEL_W-1:0]  beat_word;

  assign accept   = fetch_valid && fetch_ready;
  assign req_word = addr_q[WSEL_W-1:0];
  assign req_idx  = addr_q[WSEL_W +: INDEX_W];
  assign req_tag  = addr_q[WADDR_W-1 -: TAG_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      addr_q <= '0;
    end else begin
      pend_q <= accept;
      if (accept) begin
        addr_q <= fetch_addr[ADDR_W-1:2];
      end
    end
  end

  assign hit         = pend_q && rd_valid && (rd_tag == req_tag);
  assign miss        = pend_q && !hit;
  assign fetch_ready = !busy && !miss;
  assign rsp_valid   = hit || first_beat;
  assign rsp_data    = hit ? rd_data : mem_rdata;

  icache_tag_store #(.INDEX_W(INDEX_W), .TAG_W(TAG_W)) u_tags (
    .clk        (clk),
    .rst_n      (rst_n),
    .inv_all    (inv_all),
    .rd_idx     (req_idx),
    .rd_valid   (rd_valid),
    .rd_tag     (rd_tag),
    .alloc_en   (miss),
    .alloc_idx  (req_idx),
    .alloc_tag  (req_tag),
    .commit_en  (fill_keep),
    .commit_idx (req_idx)
  );

  icache_data_store #(.INDEX_W(INDEX_W)) u_data (
    .clk     (clk),
    .wr_en   (beat_we),
    .wr_idx  (req_idx),
    .wr_word (beat_word),
    .wr_data (mem_rdata),
    .rd_idx  (req_idx),
    .rd_word (req_word),
    .rd_data (rd_data)
  );

  icache_fill_seq #(.LINE_W(LINE_W)) u_fill (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (miss),
    .start_line  (addr_q[WADDR_W-1:WSEL_W]),
    .start_word  (req_word),
    .inv_all     (inv_all),
    .mem_req     (mem_req),
    .mem_addr    (mem_addr),
    .mem_waitreq (mem_waitreq),
    .mem_rvalid  (mem_rvalid),
    .busy        (busy),
    .beat_we     (beat_we),
    .beat_word   (beat_word),
    .first_beat  (first_beat),
    .fill_keep   (fill_keep)
  );
endmodule

// File: rtl/icache_ctrl_checker.sv
module icache_ctrl_checker #(
  parameter int ADDR_W = 31
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fetch_valid,
  input logic              fetch_ready,
  input logic              rsp_valid,
  input logic [31:0]       rsp_data,
  input logic              mem_req,
  input logic [ADDR_W-3:0] mem_addr,
  input logic              mem_waitreq,
  input logic              mem_rvalid,
  input logic [31:0]       mem_rdata
);
  // R2: an accepted fetch either responds next cycle or the port closes for a refill
  a_r2_hit_next: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && fetch_ready) |=> (rsp_valid || !fetch_ready));

  // R3: consecutive issued reads step the word select by one, line bits unchanged
  a_r3_wrap_step: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_waitreq) |=> (!mem_req ||
      (mem_addr[2:0] == $past(mem_addr[2:0]) + 3'd1 &&
       mem_addr[ADDR_W-3:3] == $past(mem_addr[ADDR_W-3:3]))));

  // R4: a response during a beat forwards the beat data
  a_r4_forward: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && mem_rvalid) |-> (rsp_data == mem_rdata));

  // R5: fetch port is closed while beats are arriving
  a_r5_closed_fill: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rvalid |-> !fetch_ready);

  // R6: a stalled read keeps strobe and address
  a_r6_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_waitreq) |=> (mem_req && $stable(mem_addr)));

  // R7: no memory traffic while the fetch port is open
  a_r7_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_ready |-> !mem_req);
endmodule

bind icache_ctrl icache_ctrl_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .fetch_valid (fetch_valid),
  .fetch_ready (fetch_ready),
  .rsp_valid   (rsp_valid),
  .rsp_data    (rsp_data),
  .mem_req     (mem_req),
  .mem_addr    (mem_addr),
  .mem_waitreq (mem_waitreq),
  .mem_rvalid  (mem_rvalid),
  .mem_rdata   (mem_rdata)
);

// File: tb/icache_ctrl_test.sv
`timescale 1ns/1ps
module icache_ctrl_test;
  localparam int ADDR_W  = 31;
  localparam int INDEX_W = 2;
  localparam int LOGN    = 4096;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              inv_all = 1'b0;
  logic              fetch_valid = 1'b0;
  logic              fetch_ready;
  logic [ADDR_W-1:0] fetch_addr = '0;
  logic              rsp_valid;
  logic [31:0]       rsp_data;
  logic              mem_req;
  logic [ADDR_W-3:0] mem_addr;
  logic              mem_waitreq = 1'b0;
  logic              mem_rvalid = 1'b0;
  logic [31:0]       mem_rdata = '0;

  int vectors = 0;
  int fails = 0;
  int nreq = 0;
  int nbeat = 0;
  int hold_viol = 0;
  int wmode = 0;
  int cyc_all = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic [ADDR_W-3:0] req_log [LOGN];
  logic              prev_stall = 1'b0;
  logic [ADDR_W-3:0] prev_addr = '0;

  always #4 clk = ~clk;

  icache_ctrl #(.ADDR_W(ADDR_W), .INDEX_W(INDEX_W)) uut (
    .clk(clk), .rst_n(rst_n), .inv_all(inv_all),
    .fetch_valid(fetch_valid), .fetch_ready(fetch_ready), .fetch_addr(fetch_addr),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_waitreq(mem_waitreq),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  function automatic logic [31:0] word_of(input logic [ADDR_W-3:0] wa);
    return (32'(wa) * 32'h9E3779B1) ^ 32'h0BADF00D;
  endfunction

  function automatic logic [ADDR_W-1:0] mk_addr(input int tg, input int idx, input int w);
    return ADDR_W'((tg << 7) | (idx << 5) | (w << 2));
  endfunction

  // memory model: one-cycle read latency, in-order beats
  always @(posedge clk) begin
    mem_rvalid <= rst_n && mem_req && !mem_waitreq;
    mem_rdata  <= word_of(mem_addr);
    if (rst_n && mem_req && !mem_waitreq) begin
      req_log[nreq % LOGN] <= mem_addr;
      nreq <= nreq + 1;
    end
    if (rst_n && mem_rvalid) nbeat <= nbeat + 1;
    if (rst_n && prev_stall && (!mem_req || mem_addr != prev_addr)) hold_viol <= hold_viol + 1;
    prev_stall <= rst_n && mem_req && mem_waitreq;
    prev_addr  <= mem_addr;
    cyc_all <= cyc_all + 1;
  end

  // stall pattern driver
  always @(negedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    case (wmode)
      1: mem_waitreq <= (cyc_all % 3 == 1);
      2: mem_waitreq <= lfsr[0];
      default: mem_waitreq <= 1'b0;
    endcase
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_fetch(input logic [ADDR_W-1:0] a, input bit exp_hit, input int inv_cyc);
    int n0, b0, got, cyc;
    logic [ADDR_W-3:0] wa;
    logic [ADDR_W-3:0] ea;
    wa = a[ADDR_W-1:2];
    @(negedge clk);
    fetch_valid = 1'b1;
    fetch_addr  = a;
    while (!fetch_ready) @(negedge clk);
    n0 = nreq;
    b0 = nbeat;
    @(negedge clk);
    fetch_valid = 1'b0;
    if (exp_hit) begin
      check(rsp_valid == 1'b1, "R2/R8 hit response", 32'(rsp_valid), 32'd1);
      check(rsp_data == word_of(wa), "R2 hit data", rsp_data, word_of(wa));
      check(fetch_ready == 1'b1, "R2 ready on hit", 32'(fetch_ready), 32'd1);
      @(negedge clk);
      check(nreq == n0, "R8 no memory read on hit", 32'(nreq - n0), 32'd0);
    end else begin
      check(rsp_valid == 1'b0, "R11 no response in miss lookup", 32'(rsp_valid), 32'd0);
      got = 0;
      cyc = 0;
      while (!fetch_ready && cyc < 400) begin
        if (rsp_valid) begin
          got++;
          check(mem_rvalid && rsp_data == word_of(wa), "R4 critical word on first beat",
                rsp_data, word_of(wa));
          check(nbeat == b0, "R4 response with first beat", 32'(nbeat - b0), 32'd0);
        end
        inv_all = (cyc == inv_cyc);
        @(negedge clk);
        cyc++;
      end
      inv_all = 1'b0;
      check(got == 1, "R11 one response per fetch", 32'(got), 32'd1);
      check(nbeat - b0 == 8, "R5 ready returns after eighth beat", 32'(nbeat - b0), 32'd8);
      check(nreq - n0 == 8, "R7 eight reads per refill", 32'(nreq - n0), 32'd8);
      for (int i = 0; i < 8; i++) begin
        ea = {wa[ADDR_W-3:3], 3'(wa[2:0] + 3'(i))};
        check(req_log[(n0 + i) % LOGN] == ea, "R3 wrapping read order",
              32'(req_log[(n0 + i) % LOGN]), 32'(ea));
      end
    end
  endtask

  int wd = 0;
  bit wd_hit = 1'b0;
  always @(posedge clk) begin
    wd <= wd + 1;
    if (wd > 150000 && !wd_hit) begin
      wd_hit = 1'b1;
      fails++;
      vectors++;
      $display("FAIL watchdog actual=%0d expected<150000", wd);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(fetch_ready == 1'b1, "R1 ready after reset", 32'(fetch_ready), 32'd1);
    check(rsp_valid == 1'b0, "R1 no response after reset", 32'(rsp_valid), 32'd0);
    check(mem_req == 1'b0, "R1 no read after reset", 32'(mem_req), 32'd0);
    do_fetch(mk_addr(0, 0, 0), 1'b0, -1);  // R1 first fetch misses

    // sweep: every line from every start word, under three stall patterns
    for (int m = 0; m < 3; m++) begin
      wmode = m;
      for (int w = 0; w < 8; w++) begin
        for (int idx = 0; idx < 4; idx++) begin
          do_fetch(mk_addr(w + 1 + 8 * m, idx, w), 1'b0, -1);  // R9 new tag evicts
          for (int k = 0; k < 8; k++) do_fetch(mk_addr(w + 1 + 8 * m, idx, k), 1'b1, -1);
        end
      end
    end
    wmode = 2;

    // R9: explicit conflict pair on one index
    do_fetch(mk_addr(100, 1, 3), 1'b0, -1);
    do_fetch(mk_addr(101, 1, 3), 1'b0, -1);
    do_fetch(mk_addr(100, 1, 3), 1'b0, -1);
    do_fetch(mk_addr(100, 2, 6), 1'b0, -1);
    do_fetch(mk_addr(100, 1, 5), 1'b1, -1);  // R9 other index untouched by conflicts

    // R2: streamed hits with fetch_valid held high
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (i > 0) begin
        check(rsp_valid && rsp_data == word_of(mk_addr(100, 1, i - 1) >> 2),
              "R2 streamed hit", rsp_data, word_of(mk_addr(100, 1, i - 1) >> 2));
        check(fetch_ready == 1'b1, "R2 ready while streaming", 32'(fetch_ready), 32'd1);
      end
      fetch_valid = 1'b1;
      fetch_addr  = mk_addr(100, 1, i);
    end
    @(negedge clk);
    fetch_valid = 1'b0;
    check(rsp_valid && rsp_data == word_of(mk_addr(100, 1, 7) >> 2),
          "R2 streamed hit", rsp_data, word_of(mk_addr(100, 1, 7) >> 2));

    // R10: idle invalidate clears all lines
    @(negedge clk);
    inv_all = 1'b1;
    @(negedge clk);
    inv_all = 1'b0;
    do_fetch(mk_addr(100, 1, 0), 1'b0, -1);
    do_fetch(mk_addr(100, 2, 6), 1'b0, -1);
    // R10: invalidate during a refill leaves that line invalid
    do_fetch(mk_addr(200, 3, 2), 1'b0, 3);
    do_fetch(mk_addr(200, 3, 2), 1'b0, -1);
    do_fetch(mk_addr(200, 3, 4), 1'b1, -1);

    check(hold_viol == 0, "R6 stalled read held", 32'(hold_viol), 32'd0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule